// File: doc/BRIEF.md
# Triggered Readout Stream Formatter

On each accept trigger this block captures a snapshot of one time slice and turns it into a readout frame of 67 words, each 16 bits wide, for a downstream serialiser. The frame is bit-sliced. Each of the 16 bit positions of the word is its own serial stream across the 67 words. Bit positions 14 down to 0 each carry one channel record. Bit position 15 carries the bunch-crossing number, then the energy sum, then the jet-hit word. The last word of every frame holds one odd parity bit for each lane.

Between frames the block sends fill beats, which are flagged and carry zero. The serialiser turns these into idle fill frames. A frame may start only after a minimum number of fill beats has been accepted. Triggers that arrive while a frame is being sent are stored in a small queue of snapshots. If a trigger finds the queue full, it is dropped and flagged.

The output is a valid/ready stream. After reset `out_valid_o` stays high, so every beat is either a frame word or a fill beat. When `out_ready_i` is low, the block holds the presented beat unchanged, and no beat is lost or repeated. Back-pressure stretches a frame in time, but a frame never has a fill beat inside it. The trigger input has no ready signal: a trigger is a one-cycle strobe that samples the snapshot inputs in the same cycle.

Top module: `rof_readout_fmt`

## Requirements
- R1: While `rst_n` is low, `out_valid_o` and `ovf_o` are 0. The first beat presented after reset is a fill beat (`out_fill_o`=1).
- R2: Each accepted trigger produces exactly 67 consecutive accepted data beats (`out_fill_o`=0), with no fill beat among them.
- R3: For lanes c = 0..14, the channel record is the 11-bit field `snap_chan_i[c*11 +: 11]`: bits 10:2 are data, bit 1 is the parity-error flag and bit 0 is the link-error flag. Word k = 0..10 of the frame carries record bit 10-k on lane c. Words 11..65 carry 0 on lane c.
- R4: Lane 15 carries the bunch number (12 bits) in words 0..11, the energy sum (25 bits) in words 12..36 and the jet-hit word (25 bits) in words 37..61. Each field is sent MSB first. Words 62..65 carry 0 on lane 15.
- R5: Word 66 is the parity word. In each lane, the number of ones over the 67 words of the frame is odd.
- R6: Before the first frame after reset, and between any two frames, at least MIN_FILL fill beats are accepted. Every fill beat carries `out_word_o`=0.
- R7: While `out_valid_o`=1 and `out_ready_i`=0, `out_word_o` and `out_fill_o` hold their values into the next cycle.
- R8: Snapshots are queued up to FIFO_DEPTH pending frames, counting the frame being sent. Frames go out in trigger order.
- R9: A trigger that arrives when FIFO_DEPTH frames are pending is dropped. `ovf_o` is high in the following cycle, and no frame is produced for that trigger.
- R10: After the first clock edge out of reset, `out_valid_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Accept-trigger strobe; captures the snapshot inputs |
| snap_chan_i | input | 165 | Fifteen 11-bit channel records, channel c at bits c*11+10..c*11 |
| snap_bcn_i | input | 12 | Bunch-crossing number |
| snap_esum_i | input | 25 | Energy sum word |
| snap_jet_i | input | 25 | Jet-hit word |
| out_valid_o | output | 1 | Beat valid |
| out_ready_i | input | 1 | Downstream accepts the beat |
| out_word_o | output | 16 | Frame word, or zero during fill |
| out_fill_o | output | 1 | Beat is a fill beat |
| ovf_o | output | 1 | One-cycle flag: a trigger was dropped |

## Verification
The bench fires bursts of triggers that fill the queue exactly and then one more. A design with an off-by-one full test would either drop a snapshot it should keep, or accept a fifth one and overwrite a pending entry. All-zero and all-one snapshots test the parity word at both extremes: a parity taken as even, or cleared at the wrong beat, shows up as an even ones count in some lane. Random back-pressure during frames and fill gaps catches a sequencer that advances without a handshake, changes the beat while it is stalled, or starts a frame before the required fill beats have been accepted. Back-to-back triggers catch a missing fill gap between queued frames.

// File: rtl/rof_pkg.sv
package rof_pkg;
  localparam int CH_N       = 15;
  localparam int REC_W      = 11;
  localparam int BCN_W      = 12;
  localparam int SUM_W      = 25;
  localparam int HIT_W      = 25;
  localparam int FRAME_LEN  = 67;
  localparam int LANES      = CH_N + 1;
  localparam int LAST_IDX   = FRAME_LEN - 1;
  localparam int SUM_LANE_W = BCN_W + SUM_W + HIT_W;
  localparam int CHAN_W     = CH_N * REC_W;
  localparam int SNAP_W     = CHAN_W + SUM_LANE_W;
  localparam int IDX_W      = $clog2(FRAME_LEN);
endpackage

// File: rtl/rof_snap_fifo.sv
module rof_snap_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign push_ok = push_i & ~full;
  assign pop_ok  = pop_i & ~empty_o;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf_o  <= 1'b0;
    end else begin
      ovf_o <= push_i & full;
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rof_frame_seq.sv
module rof_frame_seq
  import rof_pkg::*;
#(
  parameter int MIN_FILL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_i,
  input  logic             empty_i,
  output logic             valid_o,
  output logic             in_data_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hs_o,
  output logic             pop_o
);
  localparam int FW = $clog2(MIN_FILL + 1);

  logic             valid_q, data_q;
  logic [IDX_W-1:0] idx_q;
  logic [FW-1:0]    fill_q;
  logic             at_last, fill_met;

  assign hs_o      = valid_q & ready_i;
  assign at_last   = data_q & (idx_q == IDX_W'(LAST_IDX));
  assign fill_met  = (int'(fill_q) + 1) >= MIN_FILL;
  assign pop_o     = hs_o & at_last;
  assign valid_o   = valid_q;
  assign in_data_o = data_q;
  assign idx_o     = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= 1'b0;
      idx_q   <= '0;
      fill_q  <= '0;
    end else begin
      valid_q <= 1'b1;
      if (hs_o) begin
        if (data_q) begin
          if (at_last) begin
            data_q <= 1'b0;
            idx_q  <= '0;
            fill_q <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end else begin
          if (!fill_met) fill_q <= fill_q + FW'(1);
          if (fill_met && !empty_i) begin
            data_q <= 1'b1;
            idx_q  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rof_lane.sv
module rof_lane
  import rof_pkg::*;
#(
  parameter int STREAM_W = REC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STREAM_W-1:0] stream_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                in_data_i,
  input  logic                hs_i,
  output logic                bit_o
);
  logic [STREAM_W-1:0] shifted;
  logic                data_bit, at_last, acc_q;

  assign shifted  = stream_i << idx_i;
  assign data_bit = shifted[STREAM_W-1];
  assign at_last  = (idx_i == IDX_W'(LAST_IDX));
  assign bit_o    = in_data_i & (at_last ? ~acc_q : data_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
    end else if (hs_i && in_data_i) begin
      acc_q <= at_last ? 1'b0 : (acc_q ^ data_bit);
    end
  end
endmodule

// File: rtl/rof_readout_fmt.sv
module rof_readout_fmt
  import rof_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int MIN_FILL   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [CHAN_W-1:0] snap_chan_i,
  input  logic [BCN_W-1:0]  snap_bcn_i,
  input  logic [SUM_W-1:0]  snap_esum_i,
  input  logic [HIT_W-1:0]  snap_jet_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [LANES-1:0]  out_word_o,
  output logic              out_fill_o,
  output logic              ovf_o
);
  logic [SNAP_W-1:0]     snap_in, head;
  logic [CHAN_W-1:0]     head_chan;
  logic [SUM_LANE_W-1:0] head_sum;
  logic                  empty, pop, hs, in_data;
  logic [IDX_W-1:0]      idx;
  logic [LANES-1:0]      lane_bits;

  assign snap_in   = {snap_chan_i, snap_bcn_i, snap_esum_i, snap_jet_i};
  assign head_chan = head[SNAP_W-1 -: CHAN_W];
  assign head_sum  = head[SUM_LANE_W-1:0];

  rof_snap_fifo #(.W(SNAP_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(trig_i), .push_data_i(snap_in),
    .pop_i(pop), .head_o(head), .empty_o(empty), .ovf_o(ovf_o)
  );

  rof_frame_seq #(.MIN_FILL(MIN_FILL)) seq_i (
    .clk(clk), .rst_n(rst_n), .ready_i(out_ready_i), .empty_i(empty),
    .valid_o(out_valid_o), .in_data_o(in_data), .idx_o(idx),
    .hs_o(hs), .pop_o(pop)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    rof_lane #(.STREAM_W(REC_W)) lane_i (
      .clk(clk), .rst_n(rst_n),
      .stream_i(head_chan[c*REC_W +: REC_W]),
      .idx_i(idx), .in_data_i(in_data), .hs_i(hs),
      .bit_o(lane_bits[c])
    );
  end

  rof_lane #(.STREAM_W(SUM_LANE_W)) sum_lane_i (
    .clk(clk), .rst_n(rst_n), .stream_i(head_sum),
    .idx_i(idx), .in_data_i(in_data), .hs_i(hs),
    .bit_o(lane_bits[LANES-1])
  );

  assign out_word_o = lane_bits;
  assign out_fill_o = ~in_data;
endmodule

// File: rtl/rof_readout_fmt_chk.sv
module rof_readout_fmt_chk
  import rof_pkg::*;
#(
  parameter int MIN_FILL = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [LANES-1:0] out_word_o,
  input logic             out_fill_o,
  input logic             ovf_o
);
  logic [7:0] beats_q, gap_q;
  logic       hs;
  assign hs = out_valid_o & out_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats_q <= '0;
      gap_q   <= '0;
    end else if (hs) begin
      if (!out_fill_o) begin
        beats_q <= beats_q + 8'd1;
        gap_q   <= '0;
      end else begin
        beats_q <= '0;
        if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
      end
    end
  end

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> $stable(out_word_o) && $stable(out_fill_o)); // R7
  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> out_valid_o); // R10
  AST_FIRST_IS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> out_fill_o); // R1
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_fill_o) |-> beats_q == 8'(FRAME_LEN)); // R2
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_fill_o) |-> int'(gap_q) >= MIN_FILL); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(trig_i)); // R9
endmodule

bind rof_readout_fmt rof_readout_fmt_chk #(.MIN_FILL(MIN_FILL)) chk_i (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_word_o(out_word_o),
  .out_fill_o(out_fill_o), .ovf_o(ovf_o)
);

// File: tb/rof_readout_fmt_tb_top.sv
module rof_readout_fmt_tb_top;
  localparam int DEPTH = 4;
  localparam int MINF  = 1;
  localparam int LASTW = 66;

  typedef struct packed {
    logic [164:0] ch;
    logic [11:0]  bcn;
    logic [24:0]  es;
    logic [24:0]  jh;
  } snap_t;

  logic clk = 0, rst_n = 0, trig = 0, ready = 1;
  logic [164:0] chan = '0;
  logic [11:0]  bcn = '0;
  logic [24:0]  esum = '0, jet = '0;
  logic out_valid, out_fill, ovf;
  logic [15:0] out_word;

  always #10 clk = ~clk;

  rof_readout_fmt #(.FIFO_DEPTH(DEPTH), .MIN_FILL(MINF)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .snap_chan_i(chan),
    .snap_bcn_i(bcn), .snap_esum_i(esum), .snap_jet_i(jet),
    .out_valid_o(out_valid), .out_ready_i(ready), .out_word_o(out_word),
    .out_fill_o(out_fill), .ovf_o(ovf)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  snap_t q[$];
  bit m_valid = 0, m_data = 0, m_ovf = 0;
  int m_idx = 0, m_fill = 0;
  bit m_acc[16];
  int exp_drops = 0, exp_frames = 0;
  // port-level observers
  int seen_drops = 0, seen_frames = 0, beat_cnt = 0, gap_cnt = 0;
  int ones[16];
  bit prev_stall = 0;
  logic [15:0] prev_word;
  logic prev_fill;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit lane_bit(snap_t s, int lane, int k);
    logic [10:0] rec;
    logic [61:0] v;
    if (lane < 15) begin
      rec = 11'(s.ch >> (lane * 11));
      rec = rec << k;
      return (k < 11) ? rec[10] : 1'b0;
    end
    v = {s.bcn, s.es, s.jh};
    v = v << k;
    return (k < 62) ? v[61] : 1'b0;
  endfunction

  function automatic logic [15:0] exp_word();
    logic [15:0] w = '0;
    if (!m_data) return w;
    for (int l = 15; l >= 0; l--) begin
      bit b;
      b = (m_idx == LASTW) ? !m_acc[l] : lane_bit(q[0], l, m_idx);
      w = {w[14:0], b};
    end
    return w;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
      chk(ovf == 1'b0, "R1 ovf in reset", ovf, 0);
      q.delete(); m_valid = 0; m_data = 0; m_ovf = 0; m_idx = 0; m_fill = 0;
      foreach (m_acc[l]) m_acc[l] = 0;
      prev_stall = 0;
    end else begin
      logic [15:0] ew;
      bit hs, pop, newovf;
      int size0;
      ew = exp_word();
      chk(out_valid == m_valid, "R10 valid", out_valid, m_valid);
      chk(out_fill == !m_data, "R2 R6 fill flag", out_fill, !m_data);
      if (m_data && m_idx == LASTW) chk(out_word == ew, "R5 parity word", out_word, ew);
      else if (m_data) begin
        chk(out_word[14:0] == ew[14:0], "R3 channel lanes", out_word, ew);
        chk(out_word[15] == ew[15], "R4 summary lane", out_word, ew);
      end else chk(out_word == 16'h0, "R6 fill word zero", out_word, 0);
      chk(ovf == m_ovf, "R9 overflow flag", ovf, m_ovf);
      if (ovf) seen_drops++;
      if (prev_stall) chk(out_word == prev_word && out_fill == prev_fill,
                          "R7 hold under stall", out_word, prev_word);
      prev_stall = out_valid && !ready;
      prev_word = out_word; prev_fill = out_fill;
      // port observers
      if (out_valid && ready) begin
        if (out_fill) gap_cnt++;
        else begin
          if (beat_cnt == 0) chk(gap_cnt >= MINF, "R6 fill gap", gap_cnt, MINF);
          gap_cnt = 0;
          for (int l = 0; l < 16; l++) begin
            logic [15:0] t;
            t = out_word >> l;
            ones[l] += int'(t[0]);
          end
          beat_cnt++;
          if (beat_cnt == 67) begin
            for (int l = 0; l < 16; l++) begin
              chk(ones[l] % 2 == 1, "R5 odd ones per lane", ones[l], 1);
              ones[l] = 0;
            end
            seen_frames++;
            beat_cnt = 0;
          end
        end
      end
      // advance model over the next edge
      hs = m_valid && ready;
      size0 = q.size();
      newovf = trig && (size0 == DEPTH);
      pop = 0;
      if (hs && m_data) begin
        if (m_idx == LASTW) begin
          foreach (m_acc[l]) m_acc[l] = 0;
          m_data = 0; m_fill = 0; m_idx = 0; pop = 1;
        end else begin
          for (int l = 0; l < 16; l++) m_acc[l] ^= lane_bit(q[0], l, m_idx);
          m_idx++;
        end
      end else if (hs) begin
        if (m_fill < MINF) m_fill++;
        if (m_fill >= MINF && size0 > 0) begin m_data = 1; m_idx = 0; end
      end
      if (pop) void'(q.pop_front());
      if (trig) begin
        if (size0 < DEPTH) begin
          snap_t s;
          s = {chan, bcn, esum, jet};
          q.push_back(s);
          exp_frames++;
        end else exp_drops++;
      end
      m_ovf = newovf;
      m_valid = 1;
    end
  end

  task automatic fire(snap_t s);
    @(posedge clk); #1;
    trig = 1; chan = s.ch; bcn = s.bcn; esum = s.es; jet = s.jh;
    @(posedge clk); #1;
    trig = 0;
  endtask

  function automatic snap_t rnd_snap();
    logic [255:0] r;
    r = {$urandom(), $urandom(), $urandom(), $urandom(),
         $urandom(), $urandom(), $urandom(), $urandom()};
    return r[226:0];
  endfunction

  task automatic wait_idle();
    do @(posedge clk); while (q.size() != 0 || m_data);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    snap_t s;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #2;
    chk(out_fill == 1'b1, "R1 first beat fill", out_fill, 1);
    // known pattern: R3 record layout, R4 field order
    s.ch = '0;
    for (int c = 0; c < 15; c++) s.ch = s.ch | (165'(11'h400 + c) << (c * 11));
    s.bcn = 12'hA5C; s.es = 25'h1_2345_67; s.jh = 25'h0_ABCD_E1;
    fire(s);
    wait_idle();
    // extreme patterns for parity R5
    fire('0);
    wait_idle();
    fire('1);
    wait_idle();
    // burst that fills the queue then overflows: R8, R9
    @(posedge clk); #1;
    for (int i = 0; i < DEPTH + 2; i++) begin
      s = rnd_snap();
      trig = 1; chan = s.ch; bcn = s.bcn; esum = s.es; jet = s.jh;
      @(posedge clk); #1;
    end
    trig = 0;
    wait_idle();
    // random back-pressure and triggers: R7, R6
    fork
      begin
        for (int n = 0; n < 6000; n++) begin
          @(posedge clk); #1;
          ready = ($urandom() % 4) != 0;
          s = rnd_snap();
          trig = ($urandom() % 60) == 0;
          chan = s.ch; bcn = s.bcn; esum = s.es; jet = s.jh;
        end
        @(posedge clk); #1;
        trig = 0; ready = 1;
      end
    join
    wait_idle();
    chk(seen_frames == exp_frames, "R8 frames delivered", seen_frames, exp_frames);
    chk(seen_drops == exp_drops, "R9 dropped triggers", seen_drops, exp_drops);
    chk(exp_drops > 0, "R9 overflow exercised", exp_drops, 1);
    finish_run();
  end
endmodule